// File: doc/BRIEF.md
# Double-Buffered Serial Character Transmitter

This block turns parallel characters of 5 to 8 bits into asynchronous serial frames. It runs on a clock at sixteen times the bit rate. A character written through an active-low load strobe lands in a holding buffer. When the shifter is idle, or when the current frame finishes its last stop clock, the buffer moves into the shifter on its own, so consecutive characters leave the line with no idle time between them.

Each frame is a low start bit, the data least significant bit first, an optional odd or even parity bit, and then high stop time of one bit, one and a half bits (5-bit words only) or two bits. A format word sets the frame shape. It is captured while its write enable is high. Two flags report progress: one shows that the holding buffer can take a new character, and the other shows that the shifter has finished everything it was given. After reset the block stays quiet for a fixed wake-up period before it accepts data.

Top module: `txd_framer`

## Requirements
- R1: While `rst` is high, `shift_empty` is 0, `hold_empty` is 1 and `txd` is 1. After `rst` falls, `shift_empty` stays 0 after clock edges 1 to 17 and becomes 1 after the 18th edge.
- R2: A strobe pulse on `ld_n` that falls and rises inside the wake-up period is ignored. No frame is sent and `hold_empty` stays 1.
- R3: On each clock edge where `ld_n` is 0, `din` is copied into the holding buffer. The first edge that sees `ld_n` at 1 after an edge that saw it at 0 clears `hold_empty`.
- R4: If the shifter is idle, the edge after the buffer fills moves the character into the shifter. After that edge `hold_empty` is 1, `shift_empty` is 0 and `txd` is 0 (start bit).
- R5: A frame is sent in this order: start (0), data bits from the least significant up, parity if enabled, then stop time at 1. Each start, data and parity bit lasts exactly 16 clocks.
- R6: `cfg_len` sets the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Inputs of `din` above the selected length are not sent.
- R7: `cfg_par_off` = 1 drops the parity bit. Otherwise, with `cfg_par_even` = 1 the parity bit makes the count of ones over the selected data bits plus parity even; with 0 it makes that count odd.
- R8: With `cfg_long_stop` = 0 the stop time is 16 clocks. With 1 it is 24 clocks for 5-bit words and 32 clocks for 6 to 8 bit words.
- R9: `shift_empty` stays 0 through the last stop clock. It becomes 1 on the edge that ends that clock, unless another character is waiting.
- R10: A character loaded while a frame is in progress waits in the buffer, with `hold_empty` at 0. Its start bit follows the previous frame's last stop clock directly, with no idle clock between them.
- R11: The format word is captured on every edge where `cfg_we` is 1. Changes on the format inputs while `cfg_we` is 0 have no effect. Reset loads 8 bits, no parity and the short stop.
- R12: `txd` is 1 whenever no frame is being sent, including during reset and when reset interrupts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock at 16x the bit rate |
| rst | input | 1 | Master reset, active high |
| cfg_we | input | 1 | Format word write enable |
| cfg_len | input | 2 | Word length select (0..3 gives 5..8 bits) |
| cfg_par_off | input | 1 | 1 drops the parity bit |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_long_stop | input | 1 | 1 selects the long stop time |
| ld_n | input | 1 | Active-low holding-buffer load strobe |
| din | input | 8 | Character data, least significant bit in bit 0 |
| hold_empty | output | 1 | Holding buffer can take a character |
| shift_empty | output | 1 | Shifter idle and wake-up finished |
| txd | output | 1 | Serial output, idle high |

## Verification
The frame shape is swept over every word length, every parity mode and both stop settings. The data values chosen separate the cases: all zeros and all ones show the start and stop edges and the parity sense, alternating patterns expose swapped bit order, and patterns with the high inputs set show whether unused inputs leak into short words. All 32 values of a 5-bit word are also sent with odd parity and 1.5 stop bits, which checks parity on every bit pattern and the half-bit stop length. Other runs compare an idle handoff with a second character queued mid-frame, which shows whether there is a gap between frames, and a strobe or format change made while the block should ignore it against one it should accept.

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int OS_RATE  = 16;
  localparam int MIN_BITS = 5;
  localparam int MAX_BITS = 8;
  localparam int FRAME_W  = 1 + MAX_BITS + 1 + 2;
  localparam int IDX_W    = $clog2(FRAME_W);
  localparam int PAD_W    = 1 << IDX_W;
  localparam int SUB_W    = $clog2(OS_RATE);
  localparam int CNT_W    = IDX_W + SUB_W;

  typedef logic [CNT_W-1:0]    cnt_t;
  typedef logic [MAX_BITS-1:0] word_t;
  typedef logic [PAD_W-1:0]    frame_t;

  typedef struct packed {
    logic [1:0] len;
    logic       par_off;
    logic       par_even;
    logic       long_stop;
  } fmt_t;

  localparam fmt_t FMT_RESET = '{len: 2'b11, par_off: 1'b1, par_even: 1'b0, long_stop: 1'b0};

  function automatic int word_bits(input fmt_t f);
    return MIN_BITS + int'(f.len);
  endfunction

  function automatic word_t word_mask(input fmt_t f);
    word_t m;
    m = '0;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < word_bits(f)) m[i] = 1'b1;
    return m;
  endfunction

  // Even sense: xor of data; odd sense: its complement.
  function automatic logic parity_of(input word_t d, input fmt_t f);
    return (^(d & word_mask(f))) ^ ~f.par_even;
  endfunction

  function automatic cnt_t stop_ticks(input fmt_t f);
    if (!f.long_stop)               return cnt_t'(OS_RATE);
    else if (word_bits(f) == MIN_BITS) return cnt_t'(OS_RATE + OS_RATE / 2);
    else                            return cnt_t'(2 * OS_RATE);
  endfunction

  function automatic cnt_t frame_ticks(input fmt_t f);
    int bits;
    bits = 1 + word_bits(f) + (f.par_off ? 0 : 1);
    return cnt_t'(OS_RATE * bits) + stop_ticks(f);
  endfunction

  // Bit 0 is the start bit; everything past parity is stop (1).
  function automatic frame_t frame_bits(input word_t d, input fmt_t f);
    frame_t fr;
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < word_bits(f)) fr[1 + i] = d[i];
    if (!f.par_off) fr[1 + word_bits(f)] = parity_of(d, f);
    return fr;
  endfunction

endpackage

// File: rtl/txd_wake.sv
module txd_wake #(
  parameter int WAKE_CYCLES = 18
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  logic [WW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt  <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      wcnt  <= wcnt + 1'b1;
      ready <= (wcnt == WW'(WAKE_CYCLES - 1));
    end
  end
endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
  import txd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  fmt_t fmt_in,
  output fmt_t fmt
);
  always_ff @(posedge clk) begin
    if (rst)     fmt <= FMT_RESET;
    else if (we) fmt <= fmt_in;
  end
endmodule

// File: rtl/txd_hold.sv
module txd_hold
  import txd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ready,
  input  logic  ld_n,
  input  word_t din,
  input  logic  xfer,
  output word_t hold_data,
  output logic  hold_full,
  output logic  strobe_rise
);
  logic ld_q;

  // While not ready the strobe history is forced high, so no edge is seen.
  assign strobe_rise = ready && ld_n && !ld_q;

  always_ff @(posedge clk) begin
    if (rst) ld_q <= 1'b1;
    else     ld_q <= ready ? ld_n : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                hold_data <= '0;
    else if (ready && !ld_n) hold_data <= din;
  end

  // The data captured during the low phase is already what moves on a
  // coincident transfer, so the transfer wins over the edge.
  always_ff @(posedge clk) begin
    if (rst)              hold_full <= 1'b0;
    else if (xfer)        hold_full <= 1'b0;
    else if (strobe_rise) hold_full <= 1'b1;
  end
endmodule

// File: rtl/txd_shift.sv
module txd_shift
  import txd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  fmt_t  fmt,
  input  word_t data,
  output logic  busy,
  output logic  frame_end,
  output logic  txd
);
  frame_t           frame;
  cnt_t             tcnt;
  cnt_t             tlast;
  logic [IDX_W-1:0] bidx;

  assign bidx      = tcnt[CNT_W-1 -: IDX_W];
  assign frame_end = busy && (tcnt == tlast);
  assign txd       = !busy || frame[bidx];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      tcnt  <= '0;
      tlast <= '0;
      frame <= '1;
    end else if (load) begin
      busy  <= 1'b1;
      tcnt  <= '0;
      tlast <= frame_ticks(fmt) - cnt_t'(1);
      frame <= frame_bits(data, fmt);
    end else if (busy) begin
      if (frame_end) busy <= 1'b0;
      else           tcnt <= tcnt + cnt_t'(1);
    end
  end
endmodule

// File: rtl/txd_framer.sv
module txd_framer
  import txd_pkg::*;
#(
  parameter int WAKE_CYCLES = 18
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_off,
  input  logic       cfg_par_even,
  input  logic       cfg_long_stop,
  input  logic       ld_n,
  input  logic [7:0] din,
  output logic       hold_empty,
  output logic       shift_empty,
  output logic       txd
);
  logic  ready;
  logic  busy;
  logic  frame_end;
  logic  hold_full;
  logic  strobe_rise;
  logic  xfer;
  fmt_t  fmt_in;
  fmt_t  fmt;
  word_t hold_data;

  assign fmt_in = '{len: cfg_len, par_off: cfg_par_off, par_even: cfg_par_even,
                    long_stop: cfg_long_stop};

  // Handoff when the shifter is idle or ends its last stop clock this edge.
  assign xfer = ready && hold_full && (!busy || frame_end);

  assign hold_empty  = !hold_full;
  assign shift_empty = ready && !busy;

  txd_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk  (clk),
    .rst  (rst),
    .ready(ready)
  );

  txd_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .fmt_in(fmt_in),
    .fmt   (fmt)
  );

  txd_hold u_hold (
    .clk        (clk),
    .rst        (rst),
    .ready      (ready),
    .ld_n       (ld_n),
    .din        (din),
    .xfer       (xfer),
    .hold_data  (hold_data),
    .hold_full  (hold_full),
    .strobe_rise(strobe_rise)
  );

  txd_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (xfer),
    .fmt      (fmt),
    .data     (hold_data),
    .busy     (busy),
    .frame_end(frame_end),
    .txd      (txd)
  );
endmodule

// File: rtl/txd_framer_chk.sv
module txd_framer_chk (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic hold_empty,
  input logic shift_empty,
  input logic ready,
  input logic busy,
  input logic xfer,
  input logic frame_end,
  input logic hold_full,
  input logic strobe_rise
);
  assert_wake_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (!shift_empty && hold_empty && txd));

  assert_strobe_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe_rise && !xfer) |=> !hold_empty);

  assert_handoff_R4: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (busy && !txd && hold_empty && !shift_empty));

  assert_stop_done_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !hold_full) |=> shift_empty);

  assert_no_gap_R10: assert property (@(posedge clk) disable iff (rst)
    (frame_end && hold_full) |=> (busy && !txd));

  assert_idle_high_R12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
endmodule

bind txd_framer txd_framer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .txd        (txd),
  .hold_empty (hold_empty),
  .shift_empty(shift_empty),
  .ready      (ready),
  .busy       (busy),
  .xfer       (xfer),
  .frame_end  (frame_end),
  .hold_full  (hold_full),
  .strobe_rise(strobe_rise)
);

// File: tb/sim_txd_framer.sv
`timescale 1ns/1ps
module sim_txd_framer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_off = 1'b1;
  logic       cfg_par_even = 1'b0;
  logic       cfg_long_stop = 1'b0;
  logic       ld_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic       hold_empty;
  logic       shift_empty;
  logic       txd;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  txd_framer u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_par_off(cfg_par_off), .cfg_par_even(cfg_par_even),
    .cfg_long_stop(cfg_long_stop), .ld_n(ld_n), .din(din),
    .hold_empty(hold_empty), .shift_empty(shift_empty), .txd(txd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pm: 0 none, 1 odd, 2 even
  function automatic int frame_len(input int len, input int pm, input int ls);
    int n;
    n = 5 + len;
    return 16 * (1 + n + (pm != 0 ? 1 : 0)) + (ls != 0 ? (n == 5 ? 24 : 32) : 16);
  endfunction

  function automatic logic line_at(input logic [7:0] d, input int len, input int pm,
                                   input int ls, input int j);
    int n, b, ones;
    n = 5 + len;
    b = j / 16;
    ones = 0;
    for (int i = 0; i < n; i++) ones += int'(d[i]);
    if (b == 0) return 1'b0;
    if (b <= n) return d[b-1];
    if (b == n + 1 && pm != 0) return (pm == 2) ? logic'(ones % 2) : logic'(1 - ones % 2);
    return 1'b1;
  endfunction

  task automatic set_fmt(input int len, input int pm, input int ls);
    @(negedge clk);
    cfg_len = 2'(len);
    cfg_par_off = (pm == 0);
    cfg_par_even = (pm == 2);
    cfg_long_stop = (ls != 0);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Sample k is taken after the k-th edge following the strobe release edge.
  task automatic run_frame(input logic [7:0] d, input int len, input int pm, input int ls);
    int total;
    int bad_k = -1;
    logic bad_v = 1'b0;
    total = frame_len(len, pm, ls);
    @(negedge clk);
    din = d;
    ld_n = 1'b0;
    @(negedge clk);
    ld_n = 1'b1;
    for (int k = 0; k <= total + 1; k++) begin
      @(negedge clk);
      if (k == 0) chk(hold_empty == 1'b0, "R3 buffer flag after strobe", int'(hold_empty), 0);
      if (k == 1) chk(hold_empty && !shift_empty && !txd, "R4 idle handoff",
                      int'({hold_empty, shift_empty, txd}), 4);
      if (k >= 1 && k <= total && bad_k < 0 && txd !== line_at(d, len, pm, ls, k - 1)) begin
        bad_k = k - 1;
        bad_v = txd;
      end
      if (k == total) chk(shift_empty == 1'b0, "R9 busy through last stop", int'(shift_empty), 0);
      if (k == total + 1) chk(shift_empty && txd, "R9 empty after stop", int'({shift_empty, txd}), 3);
    end
    if (bad_k >= 0)
      $display("  frame d=%h len=%0d pm=%0d ls=%0d clock %0d", d, len, pm, ls, bad_k);
    chk(bad_k < 0, "R5 R6 R7 R8 frame waveform", int'(bad_v),
        bad_k < 0 ? 0 : int'(line_at(d, len, pm, ls, bad_k)));
  endtask

  task automatic back_to_back(input logic [7:0] a, input logic [7:0] b);
    int total;
    int bad_k = -1;
    logic exp;
    total = frame_len(3, 2, 0);
    @(negedge clk);
    din = a;
    ld_n = 1'b0;
    @(negedge clk);
    ld_n = 1'b1;
    for (int k = 0; k <= 2 * total + 1; k++) begin
      @(negedge clk);
      if (k >= 1 && k <= total) exp = line_at(a, 3, 2, 0, k - 1);
      else if (k > total && k <= 2 * total) exp = line_at(b, 3, 2, 0, k - 1 - total);
      else exp = 1'b1;
      if (k >= 1 && bad_k < 0 && txd !== exp) bad_k = k;
      if (k == total) chk(hold_empty == 1'b0, "R10 second char waits", int'(hold_empty), 0);
      if (k == total + 1) chk(hold_empty && !shift_empty && !txd, "R10 handoff without gap",
                              int'({hold_empty, shift_empty, txd}), 4);
      if (k == 2 * total + 1) chk(shift_empty == 1'b1, "R9 empty after pair", int'(shift_empty), 1);
      if (k == 30) begin din = b; ld_n = 1'b0; end
      if (k == 31) ld_n = 1'b1;
    end
    chk(bad_k < 0, "R10 end-to-end waveform", bad_k, -1);
  endtask

  task automatic wake_up(input bit pulse);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      if (k == 17) chk(shift_empty == 1'b0, "R1 still waking at 17", int'(shift_empty), 0);
      if (k == 18) chk(shift_empty == 1'b1, "R1 awake at 18", int'(shift_empty), 1);
      if (pulse && k == 3) ld_n = 1'b0;
      if (pulse && k == 5) ld_n = 1'b1;
    end
  endtask

  initial begin
    bit quiet;
    repeat (4) @(negedge clk);
    chk(txd && hold_empty && !shift_empty, "R1 R12 reset outputs",
        int'({txd, hold_empty, shift_empty}), 6);

    wake_up(1'b1);
    quiet = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!(txd && hold_empty)) quiet = 1'b0;
    end
    chk(quiet, "R2 strobe during wake-up ignored", int'(quiet), 1);

    // R11: reset format is 8 bits, no parity, short stop
    run_frame(8'h96, 3, 0, 0);

    // R11: format inputs change without enable
    @(negedge clk);
    cfg_len = 2'd0; cfg_par_off = 1'b0; cfg_par_even = 1'b1; cfg_long_stop = 1'b1;
    run_frame(8'h3C, 3, 0, 0);

    for (int len = 0; len < 4; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int ls = 0; ls < 2; ls++) begin
          set_fmt(len, pm, ls);
          run_frame(8'h00, len, pm, ls);
          run_frame(8'hFF, len, pm, ls);
          run_frame(8'hA5, len, pm, ls);
          run_frame(8'h5A, len, pm, ls);
          run_frame(8'hE1, len, pm, ls);
        end

    set_fmt(0, 1, 1);
    for (int v = 0; v < 32; v++) run_frame(8'(v) | 8'hE0, 0, 1, 1);

    set_fmt(3, 2, 0);
    back_to_back(8'hC3, 8'h1E);

    // R12: reset in mid-frame
    @(negedge clk);
    din = 8'h00;
    ld_n = 1'b0;
    @(negedge clk);
    ld_n = 1'b1;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(txd && hold_empty && !shift_empty, "R12 reset during frame",
        int'({txd, hold_empty, shift_empty}), 6);
    wake_up(1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule